// File: doc/BRIEF.md
# Slave Interrupt Status Controller

This block keeps the interrupt flags for a memory-mapped write slave. It watches every write request that the slave accepts. A request with an illegal byte-enable pattern raises one flag. A request with an illegal burst length raises another. It also watches the count of outstanding write-with-response transactions and raises a third flag on the cycle that count drains to zero.

The flags are sticky. Software reads them through a small register port and clears each one by writing a one to its position. A companion enable register chooses which flags drive the single interrupt line.

The burst-length check depends on the datapath width. It applies only to a 32-bit datapath, where an odd burst count above one cannot be carried. Byte-enable legality is computed from the width: a lane pattern is legal when it is all ones, or when it is one naturally aligned run of 1, 2, 4, … lanes.

Top module: `slave_irq_status_ctrl`

## Requirements
- R1: After reset the status register, the enable register and `irqOut` are all zero.
- R2: In both the status register (offset 0x10500) and the enable register (offset 0x10504), bits [31:5] and [1:0] always read as zero.
- R3: With a 32-bit datapath, a sampled write request whose byte-enable is not one of 4'b1111, 4'b0011, 4'b1100, 4'b0001, 4'b0010, 4'b0100 or 4'b1000 sets status bit 3 at the next clock edge. 4'b0000 is illegal. A legal pattern sets nothing.
- R4: With a 32-bit datapath, a sampled write request whose burst count is odd and greater than one sets status bit 2 at the next clock edge. A count of 0, 1 or any even value sets nothing.
- R5: Status bit 4 is set at the clock edge that ends a cycle in which the pending count is zero and was nonzero in the previous cycle. A count that stays at zero does not set it again.
- R6: Status bits 4, 3 and 2 stay set until software writes the status register with a one at that position. Writing a zero at a position leaves that bit unchanged.
- R7: If a set event and a clear write land on the same status bit in the same cycle, the bit ends up set.
- R8: The enable register holds bits [4:2] of the value written to offset 0x10504. It changes only on such a write.
- R9: `irqOut` is high exactly when some status bit is set and the enable bit at the same position is also set.
- R10: Byte-enable and burst inputs are ignored in any cycle where `wrReqValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (20) | Register byte address for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| wrReqValid | input | 1 | A write request is being presented this cycle |
| wrByteEn | input | DATA_W/8 (4) | Byte-enable of the observed request |
| wrBurstCnt | input | BURST_W (8) | Burst count of the observed request |
| pendCnt | input | CNT_W (8) | Outstanding write-with-response count |
| irqOut | output | 1 | Interrupt request |

## Verification
Every flag is due one clock edge after the cycle that causes it:
- a request is latched at the first rising edge after it is driven;
- a drain to zero is latched at the edge that ends the first zero cycle.

Because the read port is combinational, a flag can be read back just after that edge. `irqOut` follows the status and enable registers in the same cycle they change.

The bench changes inputs on falling edges and holds a request for exactly one rising edge. It samples at the following falling edge, which is the first point where each result is due. The same-cycle set-and-clear case is built by presenting the clear write and the offending request in the same cycle.

// File: rtl/sisc_pkg.sv
package sisc_pkg;
  localparam int FLAG_N   = 3;
  localparam int FLAG_LSB = 2;

  typedef struct packed {
    logic setDrain;
    logic setBadBe;
    logic setBadBurst;
    logic wrStat;
    logic wrEnab;
    logic selStat;
    logic selEnab;
  } strobeT;
endpackage

// File: rtl/sisc_ctrl.sv
module sisc_ctrl
  import sisc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BURST_W  = 8,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h10500,
  parameter logic [ADDR_W-1:0] ENAB_OFF = 'h10504
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               wrReqValid,
  input  logic [DATA_W/8-1:0] wrByteEn,
  input  logic [BURST_W-1:0] wrBurstCnt,
  input  logic [CNT_W-1:0]   pendCnt,
  output strobeT             strb
);
  localparam int BE_W = DATA_W / 8;

  logic [CNT_W-1:0] prevCnt;
  logic             beOk;
  logic             burstBad;

  // Legal patterns: one naturally aligned run of 2^k lanes.
  function automatic logic beLegal(input logic [BE_W-1:0] be);
    logic ok;
    logic [BE_W-1:0] mask;
    ok = 1'b0;
    for (int sz = 1; sz <= BE_W; sz = sz * 2) begin
      for (int off = 0; off < BE_W; off = off + sz) begin
        for (int b = 0; b < BE_W; b++) begin
          mask[b] = (b >= off) && (b < off + sz);
        end
        if (be == mask) ok = 1'b1;
      end
    end
    return ok;
  endfunction

  assign beOk = beLegal(wrByteEn);

  generate
    if (DATA_W == 32) begin : gBurst32
      assign burstBad = wrBurstCnt[0] && (wrBurstCnt > BURST_W'(1));
    end else begin : gBurstWide
      assign burstBad = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevCnt <= '0;
    else       prevCnt <= pendCnt;
  end

  always_comb begin
    strb.setDrain    = (prevCnt != '0) && (pendCnt == '0);
    strb.setBadBe    = wrReqValid && !beOk;
    strb.setBadBurst = wrReqValid && burstBad;
    strb.selStat     = (regAddr == STAT_OFF);
    strb.selEnab     = (regAddr == ENAB_OFF);
    strb.wrStat      = regWrEn && strb.selStat;
    strb.wrEnab      = regWrEn && strb.selEnab;
  end
endmodule

// File: rtl/sisc_dp.sv
module sisc_dp
  import sisc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irqOut,
  output logic [FLAG_N-1:0] statVec,
  output logic [FLAG_N-1:0] enVec
);
  logic [FLAG_N-1:0] setVec;
  logic [FLAG_N-1:0] clrVec;

  assign setVec = {strb.setDrain, strb.setBadBe, strb.setBadBurst};
  assign clrVec = regWrData[FLAG_LSB +: FLAG_N] & {FLAG_N{strb.wrStat}};

  genvar i;
  generate
    for (i = 0; i < FLAG_N; i++) begin : gFlag
      always_ff @(posedge clk) begin
        if (!rstN)          statVec[i] <= 1'b0;
        else if (setVec[i]) statVec[i] <= 1'b1;
        else if (clrVec[i]) statVec[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            enVec <= '0;
    else if (strb.wrEnab) enVec <= regWrData[FLAG_LSB +: FLAG_N];
  end

  always_comb begin
    regRdData = '0;
    if (strb.selStat)      regRdData[FLAG_LSB +: FLAG_N] = statVec;
    else if (strb.selEnab) regRdData[FLAG_LSB +: FLAG_N] = enVec;
  end

  assign irqOut = |(statVec & enVec);
endmodule

// File: rtl/slave_irq_status_ctrl.sv
module slave_irq_status_ctrl
  import sisc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BURST_W  = 8,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h10500,
  parameter logic [ADDR_W-1:0] ENAB_OFF = 'h10504
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic                wrReqValid,
  input  logic [DATA_W/8-1:0] wrByteEn,
  input  logic [BURST_W-1:0]  wrBurstCnt,
  input  logic [CNT_W-1:0]    pendCnt,
  output logic                irqOut
);
  strobeT            strb;
  logic [FLAG_N-1:0] statVec;
  logic [FLAG_N-1:0] enVec;

  sisc_ctrl #(
    .DATA_W(DATA_W), .BURST_W(BURST_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .STAT_OFF(STAT_OFF), .ENAB_OFF(ENAB_OFF)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .wrReqValid(wrReqValid), .wrByteEn(wrByteEn), .wrBurstCnt(wrBurstCnt),
    .pendCnt(pendCnt), .strb(strb)
  );

  sisc_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut), .statVec(statVec), .enVec(enVec)
  );
endmodule

// File: rtl/sisc_chk.sv
module sisc_chk #(
  parameter int BE_W    = 4,
  parameter int BURST_W = 8,
  parameter int CNT_W   = 8,
  parameter int ADDR_W  = 20,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h10500,
  parameter logic [ADDR_W-1:0] ENAB_OFF = 'h10504
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [31:0]        regWrData,
  input logic [31:0]        regRdData,
  input logic               wrReqValid,
  input logic [BE_W-1:0]    wrByteEn,
  input logic [BURST_W-1:0] wrBurstCnt,
  input logic [CNT_W-1:0]   pendCnt,
  input logic               irqOut,
  input logic [2:0]         statVec,
  input logic [2:0]         enVec
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[31:5] == '0) && (regRdData[1:0] == '0));                          // R2
  AST_BADBE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statVec[1]) |-> $past(wrReqValid));                                     // R3
  AST_BURST_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statVec[0]) |-> $past(wrReqValid && wrBurstCnt[0] && (wrBurstCnt > 1))); // R4
  AST_DRAIN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statVec[2]) |-> $past(pendCnt == '0));                                  // R5
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(statVec) & ~statVec)) |-> $past(regWrEn && regAddr == STAT_OFF));     // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrEn && regAddr == STAT_OFF && regWrData[3] && wrReqValid && wrByteEn == '0)
      |-> statVec[1]);                                                            // R7
  AST_ENAB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrEn && regAddr == ENAB_OFF) |-> $stable(enVec));                   // R8
  AST_IRQ_NEEDS_ENAB: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (enVec != '0) && (statVec != '0));                                 // R9
endmodule

bind slave_irq_status_ctrl sisc_chk #(
  .BE_W(DATA_W/8), .BURST_W(BURST_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
  .STAT_OFF(STAT_OFF), .ENAB_OFF(ENAB_OFF)
) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .wrReqValid(wrReqValid),
  .wrByteEn(wrByteEn), .wrBurstCnt(wrBurstCnt), .pendCnt(pendCnt),
  .irqOut(irqOut), .statVec(statVec), .enVec(enVec)
);

// File: tb/tb_slave_irq_status_ctrl.sv
module tb_slave_irq_status_ctrl;
  localparam logic [19:0] STAT = 20'h10500;
  localparam logic [19:0] ENAB = 20'h10504;
  localparam int NVEC = 24;
  // {valid, byteEn[3:0], burst[7:0], expected {b4,b3,b2}}
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 4'b0000, 8'd1, 3'b010}, {1'b1, 4'b0001, 8'd1, 3'b000},
    {1'b1, 4'b0010, 8'd1, 3'b000}, {1'b1, 4'b0100, 8'd1, 3'b000},
    {1'b1, 4'b1000, 8'd1, 3'b000}, {1'b1, 4'b0011, 8'd1, 3'b000},
    {1'b1, 4'b1100, 8'd1, 3'b000}, {1'b1, 4'b1111, 8'd1, 3'b000},
    {1'b1, 4'b0110, 8'd1, 3'b010}, {1'b1, 4'b0101, 8'd1, 3'b010},
    {1'b1, 4'b1010, 8'd1, 3'b010}, {1'b1, 4'b1001, 8'd1, 3'b010},
    {1'b1, 4'b0111, 8'd1, 3'b010}, {1'b1, 4'b1110, 8'd1, 3'b010},
    {1'b1, 4'b1011, 8'd1, 3'b010}, {1'b1, 4'b1101, 8'd1, 3'b010},
    {1'b1, 4'b1111, 8'd3, 3'b001}, {1'b1, 4'b1111, 8'd2, 3'b000},
    {1'b1, 4'b1111, 8'd0, 3'b000}, {1'b1, 4'b1111, 8'd255, 3'b001},
    {1'b1, 4'b1111, 8'd4, 3'b000}, {1'b1, 4'b0101, 8'd5, 3'b011},
    {1'b0, 4'b0000, 8'd3, 3'b000}, {1'b0, 4'b1011, 8'd7, 3'b000}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [19:0] regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        wrReqValid;
  logic [3:0]  wrByteEn;
  logic [7:0]  wrBurstCnt;
  logic [7:0]  pendCnt;
  logic        irqOut;
  int total = 0;
  int bad = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  slave_irq_status_ctrl dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .wrReqValid(wrReqValid),
    .wrByteEn(wrByteEn), .wrBurstCnt(wrBurstCnt), .pendCnt(pendCnt),
    .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [19:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic writeReg(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic request(input logic v, input logic [3:0] be, input logic [7:0] bc);
    @(negedge clk);
    wrReqValid = v; wrByteEn = be; wrBurstCnt = bc;
    @(negedge clk);
    wrReqValid = 1'b0; wrByteEn = 4'b1111; wrBurstCnt = 8'd1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = STAT; regWrData = '0;
    wrReqValid = 1'b0; wrByteEn = 4'b1111; wrBurstCnt = 8'd1; pendCnt = 8'd5;
    repeat (3) @(negedge clk);
    pendCnt = 8'd0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(STAT, rd); check(rd == 0, "R1 status", rd, 0);
    readReg(ENAB, rd); check(rd == 0, "R1 enable", rd, 0);
    check(irqOut == 1'b0, "R1 irq", 32'(irqOut), 0);

    // table walk: R3 R4 R10
    for (int k = 0; k < NVEC; k++) begin
      request(VEC[k][15], VEC[k][14:11], VEC[k][10:3]);
      readReg(STAT, rd);
      check(rd[4:2] == VEC[k][2:0], $sformatf("R3/R4/R10 vec%0d", k),
            32'(rd[4:2]), 32'(VEC[k][2:0]));
      check(rd[31:5] == 0 && rd[1:0] == 0, "R2 status reserved", rd, 32'(rd[4:2]) << 2);
      writeReg(STAT, 32'h1C);
    end

    // R5 drain to zero
    @(negedge clk); pendCnt = 8'd3;
    @(negedge clk); pendCnt = 8'd2;
    @(negedge clk); pendCnt = 8'd0;
    @(negedge clk);
    readReg(STAT, rd); check(rd[4] == 1'b1, "R5 drain sets", 32'(rd[4]), 1);
    writeReg(STAT, 32'h10);
    repeat (4) @(negedge clk);
    readReg(STAT, rd); check(rd[4] == 1'b0, "R5 no reassert at zero", 32'(rd[4]), 0);

    // R6 sticky, zero write ignored, one write clears
    request(1'b1, 4'b0000, 8'd3);
    repeat (3) @(negedge clk);
    writeReg(STAT, 32'hFFFF_FFE3);
    readReg(STAT, rd); check(rd[4:2] == 3'b011, "R6 sticky", 32'(rd[4:2]), 3);
    writeReg(STAT, 32'h08);
    readReg(STAT, rd); check(rd[4:2] == 3'b001, "R6 clear bit3 only", 32'(rd[4:2]), 1);

    // R7 set beats clear in same cycle (bit3), bit2 clears in same write
    @(negedge clk);
    regWrEn = 1'b1; regAddr = STAT; regWrData = 32'h0C;
    wrReqValid = 1'b1; wrByteEn = 4'b0000; wrBurstCnt = 8'd2;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; wrReqValid = 1'b0; wrByteEn = 4'b1111; wrBurstCnt = 8'd1;
    readReg(STAT, rd); check(rd[4:2] == 3'b010, "R7 set wins", 32'(rd[4:2]), 2);
    writeReg(STAT, 32'h1C);

    // R8 enable register and R2 reserved
    writeReg(ENAB, 32'hFFFF_FFFF);
    readReg(ENAB, rd); check(rd == 32'h1C, "R8/R2 enable write", rd, 32'h1C);
    writeReg(STAT, 32'h0);
    readReg(ENAB, rd); check(rd == 32'h1C, "R8 unaffected", rd, 32'h1C);
    writeReg(ENAB, 32'h08);
    readReg(ENAB, rd); check(rd == 32'h08, "R8 bit3 only", rd, 32'h08);

    // R9 interrupt gating
    request(1'b1, 4'b1111, 8'd3);
    check(irqOut == 1'b0, "R9 disabled flag", 32'(irqOut), 0);
    request(1'b1, 4'b0110, 8'd1);
    check(irqOut == 1'b1, "R9 enabled flag", 32'(irqOut), 1);
    writeReg(STAT, 32'h08);
    check(irqOut == 1'b0, "R9 cleared", 32'(irqOut), 0);
    writeReg(ENAB, 32'h04);
    check(irqOut == 1'b1, "R9 enable pending bit2", 32'(irqOut), 1);
    writeReg(ENAB, 32'h00);
    check(irqOut == 1'b0, "R9 enable removed", 32'(irqOut), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule